// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This block takes an audio codec from power-off to a programmed, running state. Coming out of reset, it switches on the two codec power rails, releases the mute line and keeps the codec reset pin asserted for a fixed settling interval. It then releases that pin and waits a second interval before it sends anything on the control bus. The interval length is a parameter counted in clock cycles, so a 100 ms wait can be set for silicon and a much shorter one for simulation.

Register programming goes through an external serial control-bus master, using a request/done handshake. The sequencer places one complete register write (command byte, one or two payload bytes and a length flag) on its outputs. It holds that write until the master reports it finished, then moves to the next one. The codec is reset twice. The first write sets the soft-reset bit in the status register. The reset pin is then pulsed low. The status write is repeated with the bit cleared, and after that come the status, direct data and six extended registers in a fixed order. A ready flag rises when the last write is accepted.

Top module: `codec_boot_seq`

## Requirements
- R1: While `rst` is high: both power enables low, `codec_rst_n` low, `mute` high, `cmd_req` low, `ready` low.
- R2: On the first clock edge with `rst` low, both power enables rise and `mute` falls. They then hold until the next reset. `codec_rst_n` stays low at that edge.
- R3: `codec_rst_n` rises exactly DELAY_CYC cycles after the power enables rise. The first `cmd_req` rises exactly DELAY_CYC cycles after that. No request is made while `codec_rst_n` is low.
- R4: Every command byte is `{DEV_ADDR[5:0], kind[1:0]}`. Kind 2'b10 selects the status registers and 2'b00 the data registers.
- R5: `cmd_req` stays high, and the write fields stay stable, until `cmd_done` is sampled high. `cmd_req` falls on that edge. The next write's `cmd_req` rises one cycle later, except in the case covered by R7.
- R6: Write 0 is a status write of one byte. Bit 6 is the soft-reset bit and is 1. Bits 5:4 = 2'b10 select the 256x system clock. Bits 3:1 = 3'b001 select the 16-bit LSB-justified format. Bits 7 and 0 are 0, so the byte is 8'h62.
- R7: On the edge that accepts write 0, `codec_rst_n` falls. It stays low for PULSE_CYC cycles and rises on the same edge as the `cmd_req` of write 1. Write 1 is the status byte of R6 with bit 6 cleared (8'h22).
- R8: Writes 2 to 6 are one byte each. Write 2 is status byte 8'h22. Write 3 is status `{1'b1, ST1_VAL}`. Writes 4, 5 and 6 are data bytes `{2'b00, DAT0_VAL}`, `{2'b01, DAT1_VAL}` and `{2'b10, DAT2_VAL}`.
- R9: Writes 7 to 12 are two-byte data-kind writes for extended registers n = 0 to 5, in ascending order. The first payload byte is `{5'b11000, n[2:0]}` and the second is `{3'b111, EXT_VAL[5n+4:5n]}`. `cmd_two` is high only for these writes.
- R10: `ready` rises on the edge that accepts write 12, after exactly 13 writes. It holds until reset, and no further request is made.
- R11: A `cmd_done` pulse while `cmd_req` is low changes no output.
- R12: Asserting `rst` at any point, including mid-sequence or after `ready`, returns the block to the R1 state. The whole sequence then restarts from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_done | input | 1 | Pulse from the bus master: the current write is finished |
| pwr_main_en | output | 1 | Codec core power enable |
| pwr_amp_en | output | 1 | Codec output-stage power enable |
| codec_rst_n | output | 1 | Codec hardware reset pin, active low |
| mute | output | 1 | Codec mute line, high = muted |
| cmd_req | output | 1 | A register write is presented to the bus master |
| cmd_byte | output | 8 | Command byte (device address and register kind) |
| cmd_arg0 | output | 8 | First payload byte |
| cmd_arg1 | output | 8 | Second payload byte, valid when `cmd_two` is high |
| cmd_two | output | 1 | High when the write carries two payload bytes |
| ready | output | 1 | Programming sequence complete |

## Verification
Every output is registered, so each result shows up one edge after the event that causes it. The power and mute change one cycle after reset release. The reset pin is released DELAY_CYC cycles later, and the first request comes another DELAY_CYC cycles after that. A request drops on the edge that samples `cmd_done`, and `codec_rst_n` stays low for exactly PULSE_CYC cycles. The bench has a behavioural model that applies these same counts at each rising edge and compares every output at the following falling edge, so an output that is one cycle early or late fails. The bench's bus master answers after a latency that varies from write to write. Stray done pulses, a reset in the middle of the sequence and a reset after completion are also applied.

// File: rtl/codec_boot_pkg.sv
package codec_boot_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PWR_WAIT,
        ST_RST_WAIT,
        ST_ISSUE,
        ST_PULSE,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] arg0;
        logic [7:0] arg1;
        logic       two;
    } reg_write_t;

    localparam int N_WRITES = 13;
    localparam int N_EXT    = 6;
    localparam int EXT_BASE = 7;
    localparam int IDX_W    = $clog2(N_WRITES + 1);

    localparam logic [1:0] KIND_STATUS = 2'b10;
    localparam logic [1:0] KIND_DATA   = 2'b00;
    localparam logic [1:0] SYSCLK_256  = 2'b10;
    localparam logic [2:0] FMT_LSB16   = 3'b001;

    function automatic logic [7:0] make_cmd(input logic [5:0] dev, input logic [1:0] kind);
        return {dev, kind};
    endfunction

    function automatic logic [7:0] status0_byte(input logic soft_rst);
        return {1'b0, soft_rst, SYSCLK_256, FMT_LSB16, 1'b0};
    endfunction

endpackage

// File: rtl/cbs_timer.sv
module cbs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          expire
);
    logic [CW-1:0] cnt;
    logic          busy;

    assign expire = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= len - CW'(1);
            busy <= 1'b1;
        end else if (expire) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/cbs_script.sv
module cbs_script
    import codec_boot_pkg::*;
#(
    parameter logic [5:0]  DEV_ADDR = 6'h05,
    parameter logic [6:0]  ST1_VAL  = 7'h60,
    parameter logic [5:0]  DAT0_VAL = 6'h00,
    parameter logic [5:0]  DAT1_VAL = 6'h00,
    parameter logic [5:0]  DAT2_VAL = 6'h20,
    parameter logic [29:0] EXT_VAL  = 30'h0000_7884
) (
    input  logic [IDX_W-1:0] idx,
    output reg_write_t       wr
);
    localparam logic [7:0] CMD_ST = make_cmd(DEV_ADDR, KIND_STATUS);
    localparam logic [7:0] CMD_DT = make_cmd(DEV_ADDR, KIND_DATA);

    reg_write_t tbl [N_WRITES];

    assign tbl[0] = '{cmd: CMD_ST, arg0: status0_byte(1'b1), arg1: 8'h00, two: 1'b0};
    assign tbl[1] = '{cmd: CMD_ST, arg0: status0_byte(1'b0), arg1: 8'h00, two: 1'b0};
    assign tbl[2] = '{cmd: CMD_ST, arg0: status0_byte(1'b0), arg1: 8'h00, two: 1'b0};
    assign tbl[3] = '{cmd: CMD_ST, arg0: {1'b1, ST1_VAL},     arg1: 8'h00, two: 1'b0};
    assign tbl[4] = '{cmd: CMD_DT, arg0: {2'b00, DAT0_VAL},   arg1: 8'h00, two: 1'b0};
    assign tbl[5] = '{cmd: CMD_DT, arg0: {2'b01, DAT1_VAL},   arg1: 8'h00, two: 1'b0};
    assign tbl[6] = '{cmd: CMD_DT, arg0: {2'b10, DAT2_VAL},   arg1: 8'h00, two: 1'b0};

    // R9: extended registers in ascending order, address byte then value byte
    for (genvar n = 0; n < N_EXT; n++) begin : g_ext
        assign tbl[EXT_BASE+n] = '{cmd:  CMD_DT,
                                   arg0: {5'b11000, 3'(n)},
                                   arg1: {3'b111, EXT_VAL[5*n +: 5]},
                                   two:  1'b1};
    end

    always_comb begin
        wr = '0;
        for (int k = 0; k < N_WRITES; k++) begin
            if (idx == IDX_W'(k)) wr = tbl[k];
        end
    end
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
    import codec_boot_pkg::*;
#(
    parameter int          DELAY_CYC = 12_500_000,
    parameter int          PULSE_CYC = 8,
    parameter logic [5:0]  DEV_ADDR  = 6'h05,
    parameter logic [6:0]  ST1_VAL   = 7'h60,
    parameter logic [5:0]  DAT0_VAL  = 6'h00,
    parameter logic [5:0]  DAT1_VAL  = 6'h00,
    parameter logic [5:0]  DAT2_VAL  = 6'h20,
    parameter logic [29:0] EXT_VAL   = 30'h0000_7884
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_done,
    output logic       pwr_main_en,
    output logic       pwr_amp_en,
    output logic       codec_rst_n,
    output logic       mute,
    output logic       cmd_req,
    output logic [7:0] cmd_byte,
    output logic [7:0] cmd_arg0,
    output logic [7:0] cmd_arg1,
    output logic       cmd_two,
    output logic       ready
);
    localparam int MAXW = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0]    DLY_LEN  = CW'(DELAY_CYC);
    localparam logic [CW-1:0]    PLS_LEN  = CW'(PULSE_CYC);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WRITES - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             pwr_q;
    logic             tmr_start;
    logic [CW-1:0]    tmr_len;
    logic             tmr_exp;
    logic             accept;
    reg_write_t       cur;

    assign accept = (state == ST_ISSUE) && cmd_req && cmd_done;

    always_comb begin
        tmr_start = 1'b0;
        tmr_len   = DLY_LEN;
        if (state == ST_OFF) begin
            tmr_start = 1'b1;
        end else if (state == ST_PWR_WAIT && tmr_exp) begin
            tmr_start = 1'b1;
        end else if (accept && idx == '0) begin
            tmr_start = 1'b1;
            tmr_len   = PLS_LEN;
        end
    end

    cbs_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .len    (tmr_len),
        .expire (tmr_exp)
    );

    cbs_script #(
        .DEV_ADDR (DEV_ADDR),
        .ST1_VAL  (ST1_VAL),
        .DAT0_VAL (DAT0_VAL),
        .DAT1_VAL (DAT1_VAL),
        .DAT2_VAL (DAT2_VAL),
        .EXT_VAL  (EXT_VAL)
    ) u_script (
        .idx (idx),
        .wr  (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_OFF;
            idx         <= '0;
            pwr_q       <= 1'b0;
            codec_rst_n <= 1'b0;
            mute        <= 1'b1;
            cmd_req     <= 1'b0;
            ready       <= 1'b0;
        end else begin
            case (state)
                ST_OFF: begin
                    pwr_q <= 1'b1;
                    mute  <= 1'b0;
                    state <= ST_PWR_WAIT;
                end
                ST_PWR_WAIT: begin
                    if (tmr_exp) begin
                        codec_rst_n <= 1'b1;
                        state       <= ST_RST_WAIT;
                    end
                end
                ST_RST_WAIT: begin
                    if (tmr_exp) begin
                        cmd_req <= 1'b1;
                        state   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_req) begin
                        if (cmd_done) begin
                            cmd_req <= 1'b0;
                            idx     <= idx + IDX_W'(1);
                            if (idx == '0) begin
                                codec_rst_n <= 1'b0;
                                state       <= ST_PULSE;
                            end else if (idx == LAST_IDX) begin
                                ready <= 1'b1;
                                state <= ST_READY;
                            end
                        end
                    end else begin
                        cmd_req <= 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (tmr_exp) begin
                        codec_rst_n <= 1'b1;
                        cmd_req     <= 1'b1;
                        state       <= ST_ISSUE;
                    end
                end
                ST_READY: ;
                default: state <= ST_OFF;
            endcase
        end
    end

    assign pwr_main_en = pwr_q;
    assign pwr_amp_en  = pwr_q;
    assign cmd_byte    = cur.cmd;
    assign cmd_arg0    = cur.arg0;
    assign cmd_arg1    = cur.arg1;
    assign cmd_two     = cur.two;
endmodule

// File: rtl/codec_boot_chk.sv
module codec_boot_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_done,
    input logic       pwr_main_en,
    input logic       pwr_amp_en,
    input logic       codec_rst_n,
    input logic       cmd_req,
    input logic [7:0] cmd_byte,
    input logic [7:0] cmd_arg0,
    input logic [7:0] cmd_arg1,
    input logic       cmd_two,
    input logic       ready
);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_req && !cmd_done |=> cmd_req && $stable({cmd_byte, cmd_arg0, cmd_arg1, cmd_two}));

    assert_req_drop_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_req && cmd_done |=> !cmd_req);

    assert_ready_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready && !cmd_req);

    assert_power_hold_R2: assert property (@(posedge clk) disable iff (rst)
        pwr_main_en |=> pwr_main_en && pwr_amp_en);

    assert_pulse_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(codec_rst_n) |-> !cmd_req && pwr_main_en);

    assert_no_req_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> codec_rst_n);
endmodule

bind codec_boot_seq codec_boot_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_done    (cmd_done),
    .pwr_main_en (pwr_main_en),
    .pwr_amp_en  (pwr_amp_en),
    .codec_rst_n (codec_rst_n),
    .cmd_req     (cmd_req),
    .cmd_byte    (cmd_byte),
    .cmd_arg0    (cmd_arg0),
    .cmd_arg1    (cmd_arg1),
    .cmd_two     (cmd_two),
    .ready       (ready)
);

// File: tb/codec_boot_seq_tb.sv
module codec_boot_seq_tb;
    localparam int          DLY  = 20;
    localparam int          PLS  = 3;
    localparam logic [5:0]  DEV  = 6'h05;
    localparam logic [6:0]  ST1  = 7'h60;
    localparam logic [5:0]  D0   = 6'h13;
    localparam logic [5:0]  D1   = 6'h05;
    localparam logic [5:0]  D2   = 6'h20;
    localparam logic [29:0] EXTV = 30'h0000_7884;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic done_m = 1'b0;
    logic done_s = 1'b0;
    logic cmd_done;
    logic pwr_main_en, pwr_amp_en, codec_rst_n, mute, cmd_req, cmd_two, ready;
    logic [7:0] cmd_byte, cmd_arg0, cmd_arg1;

    assign cmd_done = done_m | done_s;
    always #4 clk = ~clk;

    codec_boot_seq #(
        .DELAY_CYC (DLY), .PULSE_CYC (PLS), .DEV_ADDR (DEV), .ST1_VAL (ST1),
        .DAT0_VAL (D0), .DAT1_VAL (D1), .DAT2_VAL (D2), .EXT_VAL (EXTV)
    ) u_dut (
        .clk (clk), .rst (rst), .cmd_done (cmd_done),
        .pwr_main_en (pwr_main_en), .pwr_amp_en (pwr_amp_en),
        .codec_rst_n (codec_rst_n), .mute (mute), .cmd_req (cmd_req),
        .cmd_byte (cmd_byte), .cmd_arg0 (cmd_arg0), .cmd_arg1 (cmd_arg1),
        .cmd_two (cmd_two), .ready (ready)
    );

    int checks = 0;
    int fails  = 0;
    int run    = 0;
    bit live   = 0;

    // behavioural reference model
    int m_phase = 0, m_cnt = 0, m_idx = 0, m_nwr = 0;
    bit m_pwr = 0, m_rstn = 0, m_mute = 1, m_req = 0, m_ready = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void exp_wr(input int k, output logic [7:0] c, output logic [7:0] a0,
                                   output logic [7:0] a1, output logic two);
        c = {DEV, 2'b00}; a0 = 8'h00; a1 = 8'h00; two = 1'b0;
        if (k == 0)       begin c = {DEV, 2'b10}; a0 = 8'h62; end
        else if (k <= 2)  begin c = {DEV, 2'b10}; a0 = 8'h22; end
        else if (k == 3)  begin c = {DEV, 2'b10}; a0 = {1'b1, ST1}; end
        else if (k == 4)  a0 = {2'b00, D0};
        else if (k == 5)  a0 = {2'b01, D1};
        else if (k == 6)  a0 = {2'b10, D2};
        else begin
            a0  = {5'b11000, 3'(k - 7)};
            a1  = {3'b111, EXTV[5*(k-7) +: 5]};
            two = 1'b1;
        end
    endfunction

    always @(posedge clk) begin
        live = 1;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_idx = 0; m_nwr = 0;
            m_pwr = 0; m_rstn = 0; m_mute = 1; m_req = 0; m_ready = 0;
        end else begin
            case (m_phase)
                0: begin m_pwr = 1; m_mute = 0; m_cnt = DLY; m_phase = 1; end
                1: begin m_cnt--; if (m_cnt == 0) begin m_rstn = 1; m_cnt = DLY; m_phase = 2; end end
                2: begin m_cnt--; if (m_cnt == 0) begin m_req = 1; m_phase = 3; end end
                3: begin
                    if (m_req) begin
                        if (cmd_done) begin
                            m_req = 0; m_nwr++;
                            if (m_idx == 0) begin m_rstn = 0; m_cnt = PLS; m_phase = 4; end
                            else if (m_idx == 12) begin m_ready = 1; m_phase = 5; end
                            m_idx++;
                        end
                    end else m_req = 1;
                end
                4: begin m_cnt--; if (m_cnt == 0) begin m_rstn = 1; m_req = 1; m_phase = 3; end end
                default: ;
            endcase
        end
    end

    // compare every output at the falling edge
    always @(negedge clk) begin
        if (live) begin
            logic [7:0] ec, ea0, ea1;
            logic       etwo;
            string t_pm;
            t_pm = rst ? ((run > 0) ? "R12" : "R1") : "R2";
            chk(pwr_main_en == m_pwr && pwr_amp_en == m_pwr, t_pm, {pwr_main_en, pwr_amp_en}, {m_pwr, m_pwr});
            chk(mute == m_mute, t_pm, mute, m_mute);
            chk(codec_rst_n == m_rstn, (m_phase == 4 || m_idx >= 1) ? "R7" : "R3", codec_rst_n, m_rstn);
            chk(cmd_req == m_req, (m_phase <= 2) ? "R3" : "R5", cmd_req, m_req);
            chk(ready == m_ready, "R10", ready, m_ready);
            if (m_req && cmd_req) begin
                exp_wr(m_idx, ec, ea0, ea1, etwo);
                chk(cmd_byte[7:2] == DEV, "R4", cmd_byte, ec);
                chk(cmd_byte == ec && cmd_arg0 == ea0 && cmd_two == etwo && (!etwo || cmd_arg1 == ea1),
                    (m_idx == 0) ? "R6" : (m_idx == 1) ? "R7" : (m_idx <= 6) ? "R8" : "R9",
                    {cmd_byte, cmd_arg0, cmd_arg1, 7'd0, cmd_two}, {ec, ea0, ea1, 7'd0, etwo});
            end
        end
    end

    // bus master with per-write latency of 1..4 cycles
    int wcnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            done_m = 0; wcnt = 0;
        end else if (done_m) begin
            done_m = 0; wcnt = 0;
        end else if (cmd_req) begin
            wcnt++;
            if (wcnt >= (m_idx % 4) + 1) done_m = 1;
        end else wcnt = 0;
    end

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic wait_ready;
        while (!ready) @(negedge clk);
    endtask

    initial begin
        logic [15:0] snap;
        repeat (3) @(negedge clk);
        rst = 0;
        wait_ready();
        chk(m_nwr == 13, "R10", m_nwr, 13);
        repeat (3) @(negedge clk);
        // R11: stray done after completion
        snap = {pwr_main_en, pwr_amp_en, codec_rst_n, mute, cmd_req, ready, cmd_byte, 2'b00};
        done_s = 1;
        @(negedge clk);
        done_s = 0;
        @(negedge clk);
        chk({pwr_main_en, pwr_amp_en, codec_rst_n, mute, cmd_req, ready, cmd_byte, 2'b00} == snap,
            "R11", {pwr_main_en, pwr_amp_en, codec_rst_n, mute, cmd_req, ready, cmd_byte, 2'b00}, snap);

        // R12: reset after ready, then reset mid-sequence
        run = 1;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        repeat (5) @(negedge clk);
        // R11: stray done during the first wait
        snap = {pwr_main_en, pwr_amp_en, codec_rst_n, mute, cmd_req, ready, 10'd0};
        done_s = 1;
        @(negedge clk);
        done_s = 0;
        chk({pwr_main_en, pwr_amp_en, codec_rst_n, mute, cmd_req, ready, 10'd0} == snap,
            "R11", {pwr_main_en, pwr_amp_en, codec_rst_n, mute, cmd_req, ready, 10'd0}, snap);
        while (m_idx < 5) @(negedge clk);
        run = 2;
        rst = 1;
        repeat (2) @(negedge clk);
        chk(!cmd_req && !ready && !codec_rst_n && mute, "R12", {cmd_req, ready, codec_rst_n, mute}, 4'b0001);
        rst = 0;
        wait_ready();
        chk(m_nwr == 13, "R12", m_nwr, 13);
        repeat (4) @(negedge clk);
        report();
    end
endmodule